// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port on a simple register bus. Software reaches it through a word address, a write strobe, write data, a read strobe and read data that is registered, so it appears one cycle after the read strobe. Each pin has a direction bit. Output pins drive a stored output value. Input pins are sampled through a two-stage synchroniser before any read can see them.

The data window covers the word indices 0x000 to 0x0FF, which are the byte offsets 0x000 to 0x3FC. The low eight bits of the word index act as a pin mask for the access. A write changes only the selected output bits. A read returns zero in every unselected bit position. Software can therefore set, clear or sample any group of pins in one access, with no read-modify-write sequence.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the direction bits and the output value are all zero. pin_oe and pin_out are 0x00, and both a full-mask data read and a direction read return 0x00.
- R2: A write to data-window word index i sets output bit n to wdata bit n for every n where index bit n is 1. Index bit n is byte-offset bit n+2.
- R3: A data write leaves unchanged every output bit whose index bit is 0. A write at index 0 changes nothing.
- R4: A data read at index i returns 0 in every bit n where index bit n is 0. A single pin n is read at index 1<<n.
- R5: For a selected pin whose direction bit is 1, a data read returns the stored output bit.
- R6: For a selected pin whose direction bit is 0, a data read returns the synchronised pin_in bit. Take a pin_in change made between two rising edges. Reads sampled at the first and second rising edges after the change return the old value. Reads sampled from the third rising edge on return the new value.
- R7: The direction register is at word index 0x100 (byte offset 0x400). Bit n set to 1 makes pin n an output. pin_oe equals the direction register, and a read at that index returns it.
- R8: Data writes update the stored output bits of input pins as well. pin_out always shows the stored output value, and a pin switched to output then reads the value written earlier.
- R9: Accesses to indices outside the data window and the direction register have no effect on writes and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_idx | input | 10 | Word index of the access (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered one cycle after bus_rd |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Stored output value |
| pin_oe | output | 8 | Output enable per pin (direction register) |

## Verification
The assertions check on every cycle that unselected output bits hold through a data write, and that selected bits take the written data. They also check that state stays stable when no write reaches it, and that registered read data carries no bit outside the read's mask. An unmapped read must return zero. Only the bench scenarios can show the input-synchroniser latency counted in edges, and the mix of driven and sampled bits under a mixed direction setting. They also show that a value written to an input pin appears once the pin is switched to output, and that the reset values are correct.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    REGION_NONE = 2'd0,
    REGION_DATA = 2'd1,
    REGION_DIR  = 2'd2
  } region_e;

  // Merge new data into old under a bit mask: selected bits take new_v.
  function automatic logic [7:0] merge_under_mask(input logic [7:0] old_v,
                                                  input logic [7:0] new_v,
                                                  input logic [7:0] sel);
    return (old_v & ~sel) | (new_v & sel);
  endfunction

  // Per-pin visible level: driven value for outputs, sampled input otherwise.
  function automatic logic [7:0] pin_view(input logic [7:0] dir_v,
                                          input logic [7:0] out_v,
                                          input logic [7:0] in_v);
    return (dir_v & out_v) | (~dir_v & in_v);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic stage1_q, stage2_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage1_q <= 1'b0;
        stage2_q <= 1'b0;
      end else begin
        stage1_q <= async_in[g];
        stage2_q <= stage1_q;
      end
    end
    assign sync_out[g] = stage2_q;
  end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int NUM_PINS = 8,
  parameter int DIR_IDX  = 'h100
) (
  input  logic [IDX_W-1:0]    idx,
  output region_e             region,
  output logic [NUM_PINS-1:0] mask
);
  localparam int HI_W = IDX_W - NUM_PINS;

  logic in_data_win;
  logic is_dir;

  assign in_data_win = (idx[IDX_W-1:NUM_PINS] == HI_W'(0));
  assign is_dir      = (idx == IDX_W'(DIR_IDX));
  assign mask        = idx[NUM_PINS-1:0];

  always_comb begin
    if (in_data_win)  region = REGION_DATA;
    else if (is_dir)  region = REGION_DIR;
    else              region = REGION_NONE;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_we,
  input  logic                dir_we,
  input  logic [NUM_PINS-1:0] mask,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (data_we) out_q <= merge_under_mask(out_q, wdata, mask);
      if (dir_we)  dir_q <= wdata;
    end
  end

  p_unselected_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0));

  p_selected_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (((out_q ^ $past(wdata)) & $past(mask)) == '0));

  p_out_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(out_q));

  p_dir_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q));
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = 10,
  parameter int DIR_IDX  = 'h100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    bus_idx,
  input  logic                bus_wr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  input  logic                bus_rd,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  region_e             region;
  logic [NUM_PINS-1:0] acc_mask;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] dir_q;
  logic                data_we, dir_we;
  logic                data_rd_evt, none_rd_evt;
  logic [NUM_PINS-1:0] rd_value;

  gpio_addr_decode #(.IDX_W(IDX_W), .NUM_PINS(NUM_PINS), .DIR_IDX(DIR_IDX)) u_dec (
    .idx(bus_idx), .region(region), .mask(acc_mask)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(in_sync)
  );

  assign data_we = bus_wr && (region == REGION_DATA);
  assign dir_we  = bus_wr && (region == REGION_DIR);

  gpio_port_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .dir_we(dir_we),
    .mask(acc_mask), .wdata(bus_wdata), .out_q(out_q), .dir_q(dir_q)
  );

  assign data_rd_evt = bus_rd && (region == REGION_DATA);
  assign none_rd_evt = bus_rd && (region == REGION_NONE);

  always_comb begin
    case (region)
      REGION_DATA: rd_value = pin_view(dir_q, out_q, in_sync) & acc_mask;
      REGION_DIR:  rd_value = dir_q;
      default:     rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_value;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  p_read_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_evt |=> ((bus_rdata & ~$past(acc_mask)) == '0));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    none_rd_evt |=> (bus_rdata == '0));

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_gpio_masked_port.sv
module test_gpio_masked_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] bus_idx = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_masked_port i_gpio_masked_port (
    .clk(clk), .rst_n(rst_n), .bus_idx(bus_idx), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [9:0] idx, input logic [7:0] d);
    bus_idx = idx; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] idx, output logic [7:0] d);
    bus_idx = idx; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    rd(10'h100, v); check("R1 dir read", v, 8'h00);
    rd(10'h0FF, v); check("R1 data read", v, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    wr(10'h100, 8'hFF);
    check("R7 pin_oe", pin_oe, 8'hFF);
    rd(10'h100, v); check("R7 dir read", v, 8'hFF);
  endtask

  task automatic t_masked_write();
    wr(10'h0FF, 8'hA5); check("R2 full write", pin_out, 8'hA5);
    wr(10'h002, 8'hFF); check("R2 single pin1", pin_out, 8'hA7);
    wr(10'h000, 8'hFF); check("R3 empty mask", pin_out, 8'hA7);
    wr(10'h00F, 8'h00); check("R3 low nibble clear", pin_out, 8'hA0);
  endtask

  task automatic t_masked_read();
    logic [7:0] v;
    rd(10'h0FF, v); check("R5 full read outputs", v, 8'hA0);
    rd(10'h020, v); check("R4 pin5 alone", v, 8'h20);
    rd(10'h010, v); check("R4 pin4 alone", v, 8'h00);
    rd(10'h000, v); check("R4 empty mask", v, 8'h00);
  endtask

  task automatic t_inputs();
    logic [7:0] v;
    wr(10'h100, 8'h0F);
    pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    rd(10'h0FF, v); check("R6 mixed read", v, 8'h50);
    pin_in = 8'hC3;
    rd(10'h0FF, v); check("R6 edge1 old", v, 8'h50);
    rd(10'h0FF, v); check("R6 edge2 old", v, 8'h50);
    rd(10'h0FF, v); check("R6 edge3 new", v, 8'hC0);
    rd(10'h0C0, v); check("R6 R4 masked inputs", v, 8'hC0);
  endtask

  task automatic t_input_shadow();
    logic [7:0] v;
    wr(10'h0FF, 8'hFF);
    check("R8 pin_out", pin_out, 8'hFF);
    rd(10'h0FF, v); check("R8 inputs still sampled", v, 8'hCF);
    wr(10'h100, 8'hFF);
    rd(10'h0FF, v); check("R8 after switch", v, 8'hFF);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(10'h101, 8'h00);
    wr(10'h200, 8'h00);
    wr(10'h3FF, 8'h00);
    check("R9 out unchanged", pin_out, 8'hFF);
    check("R9 oe unchanged", pin_oe, 8'hFF);
    rd(10'h100, v); check("R9 dir intact", v, 8'hFF);
    rd(10'h101, v); check("R9 read 0x404", v, 8'h00);
    rd(10'h1FF, v); check("R9 read 0x7FC", v, 8'h00);
    rd(10'h3FF, v); check("R9 read 0xFFC", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_masked_write();
    t_masked_read();
    t_inputs();
    t_input_shadow();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule